// File: doc/BRIEF.md
# Direct-Mapped Read Cache with One-Line Victim Buffer

This block is a small read-only cache for a 9-bit byte address space. The address splits into three 3-bit fields: bits [2:0] pick a byte within an 8-byte line, bits [5:3] pick one of 8 direct-mapped sets, and bits [8:6] form the tag. Next to the set array sits a single fully associative line holder. It keeps the most recently displaced line together with its complete 6-bit block address (tag and index), so a line pushed out by a set conflict can be recovered without going to memory.

A request is offered with a valid/ready handshake. The response reports one of three outcomes. A main hit returns the byte from the indexed set. A victim hit returns the byte from the buffered line, and the buffered line trades places with the line in the indexed set. A miss in both structures issues one line read on the memory port and stalls new requests until the line arrives. The fetched line is then installed, and any valid line it replaces moves into the victim buffer. Whatever line the buffer held before that is dropped.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o and mem_req_o are 0, and every line and the victim buffer are invalid, so the first access to any set is a miss even if that set held the block before reset.
- R2: resp_data_o is byte addr[2:0] of the line, where byte k occupies line bits [8k+7:8k]. The set is addr[5:3] and the tag is addr[8:6].
- R3: An accepted request that hits the indexed set returns status 1 (main hit) with resp_valid_o high in the cycle after acceptance, and it issues no memory read.
- R4: An accepted request that misses both structures raises mem_req_o for exactly one cycle, in the cycle after acceptance, with mem_addr_o = addr[8:3]. req_ready_o stays low until the response. The response carries status 3 (miss) and is given in the cycle after mem_valid_i is seen.
- R5: On a miss, a valid line in the indexed set moves into the victim buffer, and a later access to that block returns status 2 (victim hit).
- R6: A victim hit returns status 2 in the cycle after acceptance with no memory read. Afterwards the requested block hits in its set, and the line that was displaced from the set is in the victim buffer.
- R7: When a miss displaces a valid line while the victim buffer is full, the previous buffer content is discarded, and a later access to it is a miss.
- R8: A miss into an invalid set leaves the victim buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 9 | Byte address |
| resp_valid_o | output | 1 | Response valid for one cycle |
| resp_status_o | output | 2 | 1 main hit, 2 victim hit, 3 miss |
| resp_data_o | output | 8 | Addressed byte |
| mem_req_o | output | 1 | One-cycle line read request |
| mem_addr_o | output | 6 | Block address of the line read |
| mem_valid_i | input | 1 | Line read data valid |
| mem_line_i | input | 64 | Returned line |

## Verification
The hardest state to reach is a victim-buffer discard. It needs a valid line in a set, a conflicting miss that pushes that line into the buffer, and then a second conflicting miss to the same set that throws the buffered line away. The stimulus table first fills all sets, then works set 0 with blocks 00, 10 and 20 in a chain of misses and swaps, and confirms the discard when the dropped block later misses. A separate run after a fresh reset sends a miss into an empty set while the buffer is full. This shows that an invalid set pushes nothing into the buffer.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_MAIN = 2'd1,
    ST_VICT = 2'd2,
    ST_MISS = 2'd3
  } resp_stat_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_FILL = 1'b1
  } fsm_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 3,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  localparam int SETS = 1 << IDX_W;

  logic              valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS];
  logic [LINE_W-1:0] line_q  [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[s] <= 1'b0;
      else if (sel) valid_q[s] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[s]  <= wr_tag_i;
        line_q[s] <= wr_line_i;
      end
    end

    // R8
    valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q[s] |=> valid_q[s]);
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = line_q[rd_idx_i];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int BLK_W  = 6,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  look_blk_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              ld_en_i,
  input  logic              ld_valid_i,
  input  logic [BLK_W-1:0]  ld_blk_i,
  input  logic [LINE_W-1:0] ld_line_i
);
  logic              valid_q;
  logic [BLK_W-1:0]  blk_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (ld_en_i) valid_q <= ld_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_en_i) begin
      blk_q  <= ld_blk_i;
      line_q <= ld_line_i;
    end
  end

  assign hit_o  = valid_q && (blk_q == look_blk_i);
  assign line_o = line_q;

  // R8: an untouched buffer keeps its block
  vb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ld_en_i) |=> (valid_q && $stable(blk_q)));
endmodule

// File: rtl/vc_byte_sel.sv
module vc_byte_sel #(
  parameter int OFF_W  = 3,
  parameter int BYTE_W = 8,
  localparam int NB     = 1 << OFF_W,
  localparam int LINE_W = NB * BYTE_W
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lanes [NB];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lanes[b] = line_i[b*BYTE_W +: BYTE_W];
  end

  assign byte_o = lanes[off_i];
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import vc_pkg::*;
#(
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 3,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = OFF_W + IDX_W + TAG_W,
  localparam int BLK_W  = IDX_W + TAG_W,
  localparam int LINE_W = (1 << OFF_W) * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_status_o,
  output logic [BYTE_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [LINE_W-1:0] mem_line_i
);
  fsm_e              state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mem_req_q;
  logic              resp_valid_q;
  resp_stat_e        resp_stat_q;
  logic [BYTE_W-1:0] resp_data_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [OFF_W-1:0]  cur_off;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [BLK_W-1:0]  cur_blk;

  logic              accept, main_hit, vict_hit, fill_done, swap;
  logic              set_valid;
  logic [TAG_W-1:0]  set_tag;
  logic [LINE_W-1:0] set_line, vb_line, sel_line;
  logic              vb_hit_raw;
  logic [BYTE_W-1:0] sel_byte;

  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign cur_addr = (state_q == S_IDLE) ? req_addr_i : addr_q;
  assign cur_off  = cur_addr[OFF_W-1:0];
  assign cur_idx  = cur_addr[OFF_W +: IDX_W];
  assign cur_tag  = cur_addr[OFF_W+IDX_W +: TAG_W];
  assign cur_blk  = cur_addr[ADDR_W-1:OFF_W];

  vc_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (cur_idx),
    .rd_valid_o(set_valid),
    .rd_tag_o  (set_tag),
    .rd_line_o (set_line),
    .wr_en_i   (swap || fill_done),
    .wr_idx_i  (cur_idx),
    .wr_tag_i  (cur_tag),
    .wr_line_i (fill_done ? mem_line_i : vb_line)
  );

  assign main_hit  = set_valid && (set_tag == cur_tag);
  assign vict_hit  = vb_hit_raw && !main_hit;
  assign swap      = accept && vict_hit;
  assign fill_done = (state_q == S_FILL) && mem_valid_i;

  // displaced set line goes to the buffer; an empty set leaves it alone
  vc_victim_buf #(.BLK_W(BLK_W), .LINE_W(LINE_W)) u_vb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .look_blk_i(cur_blk),
    .hit_o     (vb_hit_raw),
    .line_o    (vb_line),
    .ld_en_i   (swap || (fill_done && set_valid)),
    .ld_valid_i(set_valid),
    .ld_blk_i  ({set_tag, cur_idx}),
    .ld_line_i (set_line)
  );

  assign sel_line = fill_done ? mem_line_i : (vict_hit ? vb_line : set_line);

  vc_byte_sel #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_sel (
    .line_i(sel_line),
    .off_i (cur_off),
    .byte_o(sel_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      addr_q       <= '0;
      mem_req_q    <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_stat_q  <= ST_NONE;
      resp_data_q  <= '0;
    end else begin
      mem_req_q    <= 1'b0;
      resp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          addr_q <= req_addr_i;
          if (main_hit || vict_hit) begin
            resp_valid_q <= 1'b1;
            resp_stat_q  <= main_hit ? ST_MAIN : ST_VICT;
            resp_data_q  <= sel_byte;
          end else begin
            mem_req_q <= 1'b1;
            state_q   <= S_FILL;
          end
        end
        S_FILL: if (mem_valid_i) begin
          resp_valid_q <= 1'b1;
          resp_stat_q  <= ST_MISS;
          resp_data_q  <= sel_byte;
          state_q      <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign resp_valid_o  = resp_valid_q;
  assign resp_status_o = resp_stat_q;
  assign resp_data_o   = resp_data_q;
  assign mem_req_o     = mem_req_q;
  assign mem_addr_o    = addr_q[ADDR_W-1:OFF_W];

  // R3
  main_hit_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && main_hit) |=> (resp_valid_o && resp_status_o == ST_MAIN && !mem_req_o));
  // R6
  vict_hit_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && vict_hit) |=> (resp_valid_o && resp_status_o == ST_VICT && !mem_req_o));
  // R4
  mem_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R4
  mem_req_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!req_ready_o && !resp_valid_o));
  // R4
  miss_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (resp_valid_o && resp_status_o == ST_MISS && req_ready_o));
endmodule

// File: tb/dm_victim_cache_test.sv
module dm_victim_cache_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [8:0]  req_addr_i = '0;
  logic        resp_valid_o;
  logic [1:0]  resp_status_o;
  logic [7:0]  resp_data_o;
  logic        mem_req_o;
  logic [5:0]  mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [63:0] mem_line_i = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  dm_victim_cache uut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i,
    .resp_valid_o, .resp_status_o, .resp_data_o,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_line_i
  );

  function automatic logic [63:0] mem_content(input logic [5:0] b);
    logic [63:0] l;
    for (int k = 0; k < 8; k++) l[k*8 +: 8] = 8'((int'(b) * 37 + k * 11 + 3) & 255);
    return l;
  endfunction

  // memory model: fixed latency, one line per request
  int lat_cnt = -1;
  logic [5:0] pend_blk = '0;
  always @(negedge clk_i) begin
    mem_valid_i = 1'b0;
    if (lat_cnt == 0) begin
      mem_valid_i = 1'b1;
      mem_line_i  = mem_content(pend_blk);
      lat_cnt     = -1;
    end else if (lat_cnt > 0) lat_cnt--;
    if (mem_req_o) begin
      pend_blk = mem_addr_o;
      lat_cnt  = 3;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [8:0] a, input logic [1:0] exp_st, input string req);
    int nreq = 0;
    int seen = -1;
    bit stall_ok = 1;
    bit got = 0;
    logic [63:0] l;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      if (resp_valid_o) got = 1;
      else begin
        if (mem_req_o) begin nreq++; seen = int'(mem_addr_o); end
        if (req_ready_o) stall_ok = 0;
        @(negedge clk_i);
      end
    end
    l = mem_content(a[8:3]);
    chk(got, req, "response seen", int'(got), 1);
    chk(resp_status_o == exp_st, req, $sformatf("status @%0o", a), resp_status_o, exp_st);
    // R2: byte k at bits [8k+7:8k]
    chk(resp_data_o == l[a[2:0]*8 +: 8], "R2", $sformatf("data @%0o", a),
        resp_data_o, l[a[2:0]*8 +: 8]);
    if (exp_st == 2'd3) begin
      // R4
      chk(nreq == 1, "R4", "memory reads", nreq, 1);
      chk(seen == int'(a[8:3]), "R4", "memory block", seen, a[8:3]);
      chk(stall_ok, "R4", "ready low while filling", int'(stall_ok), 1);
    end else begin
      // R3 / R6: hits never read memory
      chk(nreq == 0, req, "memory reads on hit", nreq, 0);
    end
  endtask

  localparam int NV = 19;
  // {address (octal), expected status: 1 main hit, 2 victim hit, 3 miss}
  localparam logic [10:0] VEC [NV] = '{
    {9'o000, 2'd3}, {9'o011, 2'd3}, {9'o022, 2'd3}, {9'o033, 2'd3},
    {9'o044, 2'd3}, {9'o055, 2'd3}, {9'o066, 2'd3}, {9'o077, 2'd3},
    {9'o013, 2'd1},   // R3
    {9'o107, 2'd3},   // R5: 00 -> buffer
    {9'o001, 2'd2},   // R5/R6 swap 00 back
    {9'o104, 2'd2},   // R6 swap 10 back
    {9'o102, 2'd1},   // R6 now resident
    {9'o200, 2'd3},   // 10 -> buffer, 00 dropped
    {9'o006, 2'd3},   // R7 dropped block misses
    {9'o205, 2'd2},   // R5
    {9'o100, 2'd3},   // R7
    {9'o175, 2'd3},   // R5 set 7: 07 -> buffer
    {9'o070, 2'd2}    // R6
  };
  localparam string VREQ [NV] = '{
    "R1", "R1", "R1", "R1", "R1", "R1", "R1", "R1", "R3", "R5",
    "R5", "R6", "R6", "R7", "R7", "R5", "R7", "R5", "R6"
  };

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready in reset", req_ready_o, 1);
    chk(resp_valid_o == 1'b0, "R1", "resp_valid in reset", resp_valid_o, 0);
    chk(mem_req_o == 1'b0, "R1", "mem_req in reset", mem_req_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) access(VEC[i][10:2], VEC[i][1:0], VREQ[i]);

    // R1: reset clears previously valid lines; R8: empty set keeps buffer
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    access(9'o000, 2'd3, "R1");
    access(9'o100, 2'd3, "R5");
    access(9'o010, 2'd3, "R8");
    access(9'o003, 2'd2, "R8");
    access(9'o104, 2'd2, "R6");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule